// File: doc/BRIEF.md
# Banked Pointer Window into Packet Memory

This block puts a small, byte-addressed register window in front of a paged packet memory. The host sees sixteen byte offsets. One of them, the bank selector, is reachable in every bank. Only one bank value exposes the packet-access registers. That bank holds a 16-bit pointer and a four-offset data port. The data port reads or writes one byte of a 2048-byte page for each byte strobe.

The two top pointer bits set the behaviour of the data port. One picks which page is used: the page at the head of the receive queue or the page named by the packet-number value. Both page numbers come from outside the block. The other bit picks between two modes. In auto-increment mode the byte index steps after every access and wraps inside the page. In fixed mode the pointer stays put and the low two bits of the data-port offset are added to it.

The host may issue 1-, 2- or 4-byte requests. Each request is split into byte operations, one per cycle, lowest offset first. A read returns one assembled word. The packet memory is outside the block. It is synchronous and returns read data one cycle after its enable.

Top module: `pkt_window`

## Requirements
- R1: Offset 14 holds an 8-bit bank value that is written and read back unchanged whatever the current bank; it resets to 0x00.
- R2: Offset 15 always reads 0x33, and a write to offset 15 changes nothing.
- R3: When the bank value is 0x02, offset 6 reads and writes pointer bits 7:0 and offset 7 reads and writes pointer bits 15:8.
- R4: A read of offset 7 returns pointer bits 15:8 ANDed with 0xF7, and pointer bit 11 has no effect on the byte index.
- R5: When the bank value is not 0x02, offsets 6 to 11 read 0x00, writes to them change neither the pointer nor the memory, and no memory access is issued.
- R6: Data-port accesses (offsets 8 to 11, bank 0x02) use `rx_head_page` when pointer bit 15 is 1 and `pkt_num_page` when it is 0.
- R7: With pointer bit 14 set, the byte index is pointer bits 10:0; each data-port byte access adds one to bits 10:0 modulo 2048 and leaves bits 15:11 unchanged.
- R8: With pointer bit 14 clear, the byte index is (pointer bits 10:0 + offset bits 1:0) modulo 2048 and the pointer does not change.
- R9: `host_size` 0, 1 and 2 or 3 mean 1, 2 and 4 bytes. Byte i goes to offset (host_addr + i) mod 16, in ascending order. Byte i carries data bits 8i+7:8i in both directions, and unread lanes return zero.
- R10: A 4-byte write at offset 12 issues only the bytes for offsets 14 and 15 (data bits 23:16 and 31:24).
- R11: A request is taken only while `host_busy` is low. For a read of N byte operations, `host_rvalid` pulses for one cycle N+1 clock edges after the accepting edge, and `host_busy` is low at that moment.
- R12: After reset the pointer is 0x0000, the bank value is 0x00, and `host_busy` and `host_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request strobe, taken when host_busy is low |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Starting byte offset |
| host_size | input | 2 | Access size code (R9) |
| host_wdata | input | 32 | Write data, byte i in bits 8i+7:8i |
| host_busy | output | 1 | Access in progress |
| host_rvalid | output | 1 | Read word valid, one cycle |
| host_rdata | output | 32 | Assembled read word |
| rx_head_page | input | 2 | Page at the head of the receive queue |
| pkt_num_page | input | 2 | Page from the packet-number value |
| ram_en | output | 1 | Memory byte access |
| ram_we | output | 1 | Memory write |
| ram_page | output | 2 | Memory page |
| ram_index | output | 11 | Byte index within the page |
| ram_wdata | output | 8 | Memory write byte |
| ram_rdata | input | 8 | Memory read byte, one cycle after ram_en |

## Verification
In a multi-byte auto-increment read, one cycle can hold three things at once: the byte from the previous memory read lands in its lane, the next memory read is issued, and the pointer steps. A 4-byte read and write across the page end in auto-increment mode provokes this overlap. It is judged by comparing the assembled word and the pointer read back afterwards with values worked out by hand. A second overlap comes from multi-byte accesses that span the bank selector, where a bank write lands between the other byte operations of the same request. It is judged by the bank value and the gated offsets read afterwards.

// File: rtl/pkt_window_pkg.sv
package pkt_window_pkg;
  localparam int unsigned OFF_W  = 4;
  localparam int unsigned PTR_W  = 16;
  localparam int unsigned RXSEL_BIT = 15;  // page source select
  localparam int unsigned AUTO_BIT  = 14;  // auto-increment enable

  localparam logic [OFF_W-1:0] OFF_PTR_LO = 4'd6;
  localparam logic [OFF_W-1:0] OFF_PTR_HI = 4'd7;
  localparam logic [OFF_W-1:0] OFF_WIDE   = 4'd12;
  localparam logic [OFF_W-1:0] OFF_BANK   = 4'd14;
  localparam logic [OFF_W-1:0] OFF_ID     = 4'd15;

  localparam logic [7:0] ID_BYTE     = 8'h33;
  localparam logic [7:0] PTR_HI_MASK = 8'hF7;

  typedef struct packed {
    logic             rd;
    logic             wr;
    logic [OFF_W-1:0] off;
    logic [7:0]       data;
    logic             last;
  } byte_op_t;
endpackage

// File: rtl/pkt_window_seq.sv
module pkt_window_seq
  import pkt_window_pkg::*;
#(
  parameter int unsigned HOST_W = 32,
  parameter int unsigned LANES  = HOST_W / 8,
  parameter int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              we,
  input  logic [OFF_W-1:0]  addr,
  input  logic [1:0]        size,
  input  logic [HOST_W-1:0] wdata,
  output logic              active_o,
  output byte_op_t          op_o,
  output logic [LANE_W-1:0] lane_o
);
  logic              active_q, active_d;
  logic              we_q, we_d;
  logic [OFF_W-1:0]  base_q, base_d;
  logic [HOST_W-1:0] wdata_q, wdata_d;
  logic [LANE_W-1:0] idx_q, idx_d, last_q, last_d, start_idx;
  logic [LANE_W:0]   nbytes;

  always_comb begin
    if (int'(size) >= int'(LANE_W)) nbytes = (LANE_W+1)'(LANES);
    else                             nbytes = (LANE_W+1)'(1) << size;
    // wide write at offset 12 only reaches the bank selector and offset 15
    if (we && addr == OFF_WIDE && nbytes == (LANE_W+1)'(4)) start_idx = LANE_W'(2);
    else                                                    start_idx = '0;
  end

  always_comb begin
    active_d = active_q;
    we_d     = we_q;
    base_d   = base_q;
    wdata_d  = wdata_q;
    idx_d    = idx_q;
    last_d   = last_q;
    if (accept) begin
      active_d = 1'b1;
      we_d     = we;
      base_d   = addr;
      wdata_d  = wdata;
      idx_d    = start_idx;
      last_d   = LANE_W'(nbytes - 1'b1);
    end else if (active_q) begin
      if (idx_q == last_q) active_d = 1'b0;
      else                 idx_d    = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      we_q     <= 1'b0;
      base_q   <= '0;
      wdata_q  <= '0;
      idx_q    <= '0;
      last_q   <= '0;
    end else begin
      active_q <= active_d;
      we_q     <= we_d;
      base_q   <= base_d;
      wdata_q  <= wdata_d;
      idx_q    <= idx_d;
      last_q   <= last_d;
    end
  end

  always_comb begin
    op_o.rd   = active_q && !we_q;
    op_o.wr   = active_q && we_q;
    op_o.off  = base_q + OFF_W'(idx_q);
    op_o.data = wdata_q[{idx_q, 3'b000} +: 8];
    op_o.last = (idx_q == last_q);
  end
  assign active_o = active_q;
  assign lane_o   = idx_q;

  // R9: byte operations walk upward one lane per cycle, never past the last lane
  assert_lane_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (idx_q <= last_q));
  assert_lane_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && idx_q != last_q) |=> (active_q && idx_q == $past(idx_q) + 1'b1));
  // R11: a new request never lands on a running one
  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !active_q);
  // R10: the first operation of a wide write at offset 12 is the bank write
  assert_wide_skip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && we && addr == OFF_WIDE && size == 2'd2) |=> (op_o.wr && op_o.off == OFF_BANK));
endmodule

// File: rtl/pkt_window_ptr.sv
module pkt_window_ptr
  import pkt_window_pkg::*;
#(
  parameter int unsigned PAGE_W  = 2,
  parameter int unsigned INDEX_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lo_we,
  input  logic               hi_we,
  input  logic [7:0]         wbyte,
  input  logic               access,
  input  logic [1:0]         off_lo,
  input  logic [PAGE_W-1:0]  rx_head_page,
  input  logic [PAGE_W-1:0]  pkt_num_page,
  output logic [PTR_W-1:0]   ptr_o,
  output logic [PAGE_W-1:0]  page_o,
  output logic [INDEX_W-1:0] index_o
);
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic [INDEX_W-1:0] base_idx;
  logic               auto_inc;

  assign base_idx = ptr_q[INDEX_W-1:0];
  assign auto_inc = ptr_q[AUTO_BIT];

  always_comb begin
    ptr_d = ptr_q;
    if (lo_we) ptr_d[7:0]  = wbyte;
    if (hi_we) ptr_d[15:8] = wbyte;
    if (access && auto_inc) ptr_d[INDEX_W-1:0] = base_idx + INDEX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign page_o  = ptr_q[RXSEL_BIT] ? rx_head_page : pkt_num_page;
  assign index_o = auto_inc ? base_idx : base_idx + INDEX_W'(off_lo);
  assign ptr_o   = ptr_q;

  // R8: fixed mode leaves the pointer alone across a data access
  assert_fixed_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !auto_inc) |=> (ptr_q == $past(ptr_q)));
  // R7: auto mode steps only the index field, upper bits kept
  assert_auto_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (access && auto_inc) |=> (ptr_q[PTR_W-1:INDEX_W] == $past(ptr_q[PTR_W-1:INDEX_W])
                              && ptr_q[INDEX_W-1:0] == $past(ptr_q[INDEX_W-1:0]) + INDEX_W'(1)));
endmodule

// File: rtl/pkt_window_rd.sv
module pkt_window_rd #(
  parameter int unsigned HOST_W = 32,
  parameter int unsigned LANES  = HOST_W / 8,
  parameter int unsigned LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              op_rd,
  input  logic              op_last,
  input  logic [LANE_W-1:0] lane,
  input  logic              from_ram,
  input  logic [7:0]        reg_byte,
  input  logic [7:0]        ram_rdata,
  output logic              pend_o,
  output logic              rvalid_o,
  output logic [HOST_W-1:0] rdata_o
);
  logic              pend_q, last_q, ram_q, rvalid_q;
  logic [LANE_W-1:0] lane_q;
  logic [7:0]        regb_q, rbyte;
  logic [HOST_W-1:0] acc_q, acc_d;

  assign rbyte = ram_q ? ram_rdata : regb_q;

  always_comb begin
    acc_d = acc_q;
    if (clear)  acc_d = '0;
    if (pend_q) acc_d[{lane_q, 3'b000} +: 8] = rbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      last_q   <= 1'b0;
      ram_q    <= 1'b0;
      lane_q   <= '0;
      regb_q   <= '0;
      acc_q    <= '0;
      rvalid_q <= 1'b0;
    end else begin
      pend_q   <= op_rd;
      last_q   <= op_last;
      ram_q    <= from_ram;
      lane_q   <= lane;
      regb_q   <= reg_byte;
      acc_q    <= acc_d;
      rvalid_q <= pend_q && last_q;
    end
  end

  assign pend_o   = pend_q;
  assign rvalid_o = rvalid_q;
  assign rdata_o  = acc_q;

  // R11: the word is never cleared while a lane is still landing
  assert_clear_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> !pend_q);
endmodule

// File: rtl/pkt_window.sv
module pkt_window
  import pkt_window_pkg::*;
#(
  parameter int unsigned HOST_W    = 32,
  parameter int unsigned PAGE_W    = 2,
  parameter int unsigned INDEX_W   = 11,
  parameter logic [7:0]  DATA_BANK = 8'h02
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [3:0]         host_addr,
  input  logic [1:0]         host_size,
  input  logic [HOST_W-1:0]  host_wdata,
  output logic               host_busy,
  output logic               host_rvalid,
  output logic [HOST_W-1:0]  host_rdata,
  input  logic [PAGE_W-1:0]  rx_head_page,
  input  logic [PAGE_W-1:0]  pkt_num_page,
  output logic               ram_en,
  output logic               ram_we,
  output logic [PAGE_W-1:0]  ram_page,
  output logic [INDEX_W-1:0] ram_index,
  output logic [7:0]         ram_wdata,
  input  logic [7:0]         ram_rdata
);
  localparam int unsigned LANES  = HOST_W / 8;
  localparam int unsigned LANE_W = $clog2(LANES);

  // reset asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  byte_op_t          op;
  logic [LANE_W-1:0] lane;
  logic              seq_active, rd_pend, accept;
  logic [7:0]        bank_q, bank_d, reg_byte;
  logic              in_bank, data_sel, ptr_lo_we, ptr_hi_we, data_acc;
  logic [PTR_W-1:0]  ptr;

  assign host_busy = seq_active || rd_pend;
  assign accept    = host_req && !host_busy;

  pkt_window_seq #(.HOST_W(HOST_W)) i_seq (
    .clk(clk), .rst_n(rst_ni), .accept(accept), .we(host_we), .addr(host_addr),
    .size(host_size), .wdata(host_wdata), .active_o(seq_active), .op_o(op), .lane_o(lane)
  );

  // bank selector, reachable from every bank
  always_comb begin
    bank_d = bank_q;
    if (op.wr && op.off == OFF_BANK) bank_d = op.data;
  end
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) bank_q <= 8'h00;
    else         bank_q <= bank_d;
  end

  assign in_bank   = (bank_q == DATA_BANK);
  assign data_sel  = in_bank && (op.off[3:2] == 2'b10);
  assign ptr_lo_we = op.wr && in_bank && (op.off == OFF_PTR_LO);
  assign ptr_hi_we = op.wr && in_bank && (op.off == OFF_PTR_HI);
  assign data_acc  = (op.rd || op.wr) && data_sel;

  pkt_window_ptr #(.PAGE_W(PAGE_W), .INDEX_W(INDEX_W)) i_ptr (
    .clk(clk), .rst_n(rst_ni), .lo_we(ptr_lo_we), .hi_we(ptr_hi_we), .wbyte(op.data),
    .access(data_acc), .off_lo(op.off[1:0]), .rx_head_page(rx_head_page),
    .pkt_num_page(pkt_num_page), .ptr_o(ptr), .page_o(ram_page), .index_o(ram_index)
  );

  always_comb begin
    reg_byte = 8'h00;
    if (op.off == OFF_BANK)                    reg_byte = bank_q;
    else if (op.off == OFF_ID)                 reg_byte = ID_BYTE;
    else if (in_bank && op.off == OFF_PTR_LO)  reg_byte = ptr[7:0];
    else if (in_bank && op.off == OFF_PTR_HI)  reg_byte = ptr[15:8] & PTR_HI_MASK;
  end

  pkt_window_rd #(.HOST_W(HOST_W)) i_rd (
    .clk(clk), .rst_n(rst_ni), .clear(accept), .op_rd(op.rd), .op_last(op.last),
    .lane(lane), .from_ram(data_sel), .reg_byte(reg_byte), .ram_rdata(ram_rdata),
    .pend_o(rd_pend), .rvalid_o(host_rvalid), .rdata_o(host_rdata)
  );

  assign ram_en    = data_acc;
  assign ram_we    = op.wr && data_sel;
  assign ram_wdata = op.data;

  // R2: a write at offset 15 leaves the bank value untouched
  assert_id_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (op.wr && op.off == OFF_ID) |=> $stable(bank_q));
  // R5: memory traffic only while the data bank is selected
  assert_ram_gated_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    ram_en |-> (bank_q == DATA_BANK));
  // R11: the read word appears only once the access has drained
  assert_rvalid_idle_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    host_rvalid |-> !host_busy);
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    host_rvalid |=> !host_rvalid);
  // R9: one byte operation per cycle, never both directions
  assert_one_dir_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({op.rd, op.wr}));
endmodule

// File: tb/test_pkt_window.sv
module test_pkt_window;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_we;
  logic [3:0]  host_addr;
  logic [1:0]  host_size;
  logic [31:0] host_wdata;
  logic        host_busy, host_rvalid;
  logic [31:0] host_rdata;
  logic [1:0]  rx_head_page, pkt_num_page;
  logic        ram_en, ram_we;
  logic [1:0]  ram_page;
  logic [10:0] ram_index;
  logic [7:0]  ram_wdata, ram_rdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  pkt_window i_pkt_window (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_busy(host_busy), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .rx_head_page(rx_head_page), .pkt_num_page(pkt_num_page),
    .ram_en(ram_en), .ram_we(ram_we), .ram_page(ram_page), .ram_index(ram_index),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // synchronous packet memory model, one-cycle read
  logic [7:0] mem [int];
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[int'({ram_page, ram_index})] = ram_wdata;
      else ram_rdata <= mem.exists(int'({ram_page, ram_index})) ? mem[int'({ram_page, ram_index})] : 8'h00;
    end
  end

  typedef struct packed {
    logic        we;
    logic [3:0]  addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] expv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd14, 2'd0, 32'h02,       32'h0,        4'd1},   // R1 select data bank
    '{1'b0, 4'd6,  2'd1, 32'h0,        32'h0000,     4'd12},  // R12 pointer reset value
    '{1'b0, 4'd14, 2'd0, 32'h0,        32'h02,       4'd1},   // R1
    '{1'b0, 4'd15, 2'd0, 32'h0,        32'h33,       4'd2},   // R2
    '{1'b1, 4'd15, 2'd0, 32'h55,       32'h0,        4'd2},   // R2 write ignored
    '{1'b0, 4'd14, 2'd1, 32'h0,        32'h3302,     4'd2},   // R2 bank intact, id fixed
    '{1'b1, 4'd6,  2'd1, 32'h4010,     32'h0,        4'd3},   // R3 pointer write
    '{1'b1, 4'd8,  2'd2, 32'hDDCCBBAA, 32'h0,        4'd7},   // R7 auto write
    '{1'b0, 4'd6,  2'd1, 32'h0,        32'h4014,     4'd7},   // R7 stepped by 4
    '{1'b1, 4'd6,  2'd1, 32'h0010,     32'h0,        4'd8},   // R8 fixed mode
    '{1'b0, 4'd8,  2'd2, 32'h0,        32'hDDCCBBAA, 4'd8},   // R8 index plus offset
    '{1'b0, 4'd6,  2'd1, 32'h0,        32'h0010,     4'd8},   // R8 pointer unchanged
    '{1'b1, 4'd6,  2'd1, 32'h0810,     32'h0,        4'd4},   // R4 set bit 11
    '{1'b0, 4'd6,  2'd1, 32'h0,        32'h0010,     4'd4},   // R4 high byte masked
    '{1'b0, 4'd8,  2'd0, 32'h0,        32'h000000AA, 4'd4},   // R4 bit 11 ignored in index
    '{1'b1, 4'd6,  2'd1, 32'hC7FE,     32'h0,        4'd6},   // R6 receive page, auto
    '{1'b1, 4'd8,  2'd2, 32'h44332211, 32'h0,        4'd7},   // R7 wrap at page end
    '{1'b0, 4'd6,  2'd1, 32'h0,        32'hC002,     4'd7},   // R7 wrapped pointer
    '{1'b1, 4'd6,  2'd1, 32'h87FE,     32'h0,        4'd8},   // R8 receive page, fixed
    '{1'b0, 4'd8,  2'd2, 32'h0,        32'h44332211, 4'd8},   // R8 fixed index wraps
    '{1'b1, 4'd6,  2'd1, 32'h0012,     32'h0,        4'd6},   // R6 packet-number page
    '{1'b0, 4'd8,  2'd0, 32'h0,        32'h000000CC, 4'd6},   // R6 page 1 intact
    '{1'b1, 4'd12, 2'd2, 32'h3301A5A5, 32'h0,        4'd10},  // R10 wide write at 12
    '{1'b0, 4'd14, 2'd0, 32'h0,        32'h01,       4'd10},  // R10 bank from bits 23:16
    '{1'b0, 4'd6,  2'd1, 32'h0,        32'h0000,     4'd5},   // R5 pointer hidden
    '{1'b1, 4'd8,  2'd0, 32'hEE,       32'h0,        4'd5},   // R5 data write ignored
    '{1'b1, 4'd14, 2'd0, 32'h02,       32'h0,        4'd1},   // R1
    '{1'b0, 4'd8,  2'd0, 32'h0,        32'h000000CC, 4'd5},   // R5 memory untouched
    '{1'b0, 4'd12, 2'd2, 32'h0,        32'h33020000, 4'd9},   // R9 lanes
    '{1'b0, 4'd13, 2'd2, 32'h0,        32'h00330200, 4'd9},   // R9 offset wraps
    '{1'b1, 4'd13, 2'd1, 32'h0300,     32'h0,        4'd9},   // R9 lane 1 to offset 14
    '{1'b0, 4'd14, 2'd0, 32'h0,        32'h03,       4'd9},   // R9
    '{1'b1, 4'd14, 2'd0, 32'h02,       32'h0,        4'd1},   // R1
    '{1'b1, 4'd6,  2'd1, 32'h0020,     32'h0,        4'd8},   // R8
    '{1'b1, 4'd8,  2'd2, 32'h87654321, 32'h0,        4'd8},   // R8 fixed write
    '{1'b1, 4'd6,  2'd1, 32'h4020,     32'h0,        4'd7},   // R7
    '{1'b0, 4'd8,  2'd2, 32'h0,        32'h87654321, 4'd7},   // R7 auto read
    '{1'b0, 4'd6,  2'd1, 32'h0,        32'h4024,     4'd7}    // R7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic access(input logic we, input logic [3:0] a, input logic [1:0] s,
                        input logic [31:0] wd, output logic [31:0] rd, output int lat);
    while (host_busy) @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_size = s; host_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    host_req = 1'b0;
    lat = 0;
    if (!we) begin
      while (!host_rvalid) begin
        @(posedge clk); lat++; @(negedge clk);
      end
      rd = host_rdata;
    end else begin
      while (host_busy) begin
        @(posedge clk); lat++; @(negedge clk);
      end
      rd = '0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lat;
    host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_size = '0; host_wdata = '0;
    rx_head_page = 2'd3; pkt_num_page = 2'd1; ram_rdata = 8'h00;
    do_reset();

    // R12: idle outputs and bank value after reset
    chk("R12 busy after reset", 32'(host_busy), 32'h0);
    chk("R12 rvalid after reset", 32'(host_rvalid), 32'h0);
    access(1'b0, 4'd14, 2'd0, 32'h0, rd, lat);
    chk("R12 bank after reset", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].we, VEC[i].addr, VEC[i].size, VEC[i].wdata, rd, lat);
      if (!VEC[i].we) chk($sformatf("R%0d vector %0d", VEC[i].req, i), rd, VEC[i].expv);
    end

    // R11: read latency is byte count plus one edge
    access(1'b0, 4'd15, 2'd0, 32'h0, rd, lat);
    chk("R11 one-byte read latency", 32'(lat), 32'd2);
    access(1'b0, 4'd12, 2'd2, 32'h0, rd, lat);
    chk("R11 four-byte read latency", 32'(lat), 32'd5);
    chk("R11 busy low at end", 32'(host_busy), 32'h0);

    // R12: reset in mid-run restores pointer and bank
    do_reset();
    access(1'b0, 4'd14, 2'd0, 32'h0, rd, lat);
    chk("R12 bank after second reset", rd, 32'h0);
    access(1'b1, 4'd14, 2'd0, 32'h02, rd, lat);
    access(1'b0, 4'd6, 2'd1, 32'h0, rd, lat);
    chk("R12 pointer after second reset", rd, 32'h0);

    // R3: pointer bytes written one at a time
    access(1'b1, 4'd7, 2'd0, 32'h12, rd, lat);
    access(1'b1, 4'd6, 2'd0, 32'h34, rd, lat);
    access(1'b0, 4'd6, 2'd1, 32'h0, rd, lat);
    chk("R3 separate byte writes", rd, 32'h1234);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule